// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block translates a virtual page number into a physical frame number by searching a hashed page table that lives in ordinary memory. A request carries the page number and the byte address of the table's bucket array. The engine folds the page number into a bucket index and reads that bucket's head pointer. It then walks the linked chain of elements one element at a time, comparing each stored page number with the requested one. A search ends in one of three ways: a hit that returns the frame number, a miss, or an error. The error is raised when the chain is longer than a fixed limit, which stops a corrupt chain that loops back on itself from holding the engine forever.

All table reads go through one valid/ready read port, and only one read is in flight at a time. The time a lookup takes therefore depends on how far down its chain the match sits and on how fast the memory responds. The block does not insert or remove elements, and it does not cache translations.

Top module: `hpt_walker`

## Requirements
- R1: The bucket index is formed from the 20-bit page number as h = vpn[19:10] XOR vpn[9:0], then idx = h[7:0] XOR {6'b0, h[9:8]}, giving 256 buckets. The first memory read of a lookup is the 32-bit head pointer at byte address base + 4*idx.
- R2: An element at byte address P is three 32-bit words: the page number at P (zero-extended, compared as a full word), the frame at P+4 and the next pointer at P+8. The first element read is the one the head pointer names.
- R3: When an element's page-number word equals the request, the engine reads that element's frame word. It then finishes with hit high and frame equal to that word.
- R4: When an element's page-number word differs, its frame word is never read, and the next read is that element's next pointer at P+8.
- R5: A head pointer of zero, or a next pointer of zero, ends the search with miss high.
- R6: At most 16 elements are compared per lookup. After 16 mismatches, a nonzero next pointer ends the search with err high and no further reads. A chain of exactly 16 non-matching elements that ends with a zero pointer gives a miss.
- R7: busy is high from the cycle after a request is accepted until the search ends. done is a one-cycle pulse in the cycle busy falls, and during that pulse exactly one of hit, miss and err is high. None of the three flags is high outside done.
- R8: A request presented while busy is high is ignored. It does not change the running result, and it produces no extra reads and no extra done pulse.
- R9: Once mem_rd_valid is raised, it stays high with a stable address until mem_rd_ready is seen. A new read is never issued while the previous one is unanswered.
- R10: After reset, busy, done, hit, miss, err and mem_rd_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a lookup (taken when not busy) |
| req_vpn | input | 20 | Virtual page number to translate |
| req_base | input | 32 | Byte address of the bucket array |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle end-of-lookup pulse |
| hit | output | 1 | Match found (valid with done) |
| miss | output | 1 | Chain ended without a match (valid with done) |
| err | output | 1 | Chain length limit exceeded (valid with done) |
| frame | output | 32 | Frame word of the matching element, held after a hit |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Read data valid (one cycle per accepted read) |
| mem_rsp_data | input | 32 | Read data |

## Verification
A wrong pointer or a wrong state register shows at the read port within one memory round trip, as a read to an address that the bucket arithmetic or the element layout does not predict. Because of this, the bench logs the address of every accepted read and compares the whole sequence, and the total read count, against what the chain layout implies. A hop counter that is off by one can only be seen at the chain-length boundary, so chains of exactly 16 elements, 16 elements with a match at the end, and a self-loop are each run and their read counts checked. A stuck or mistimed result register shows at the end of the lookup, as a missing, doubled or multi-flag done pulse.

// File: rtl/hpt_pkg.sv
// Shared types for the hashed page table walker.
package hpt_pkg;
    // Walk phases: idle, head pointer read, element VPN/frame/next reads.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_VPN,
        ST_FRM,
        ST_NEXT
    } walk_st_t;
endpackage

// File: rtl/hpt_hash.sv
// Bucket index generator.
// XORs the upper and lower halves of the page number, then folds the
// result down to IDX_W bits by XORing bit i into bit (i mod IDX_W).
// Assumes VPN_W is even and VPN_W/2 >= IDX_W. Purely combinational.
module hpt_hash #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 8
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    localparam int HALF = VPN_W / 2;

    logic [HALF-1:0] mix;

    assign mix = vpn[VPN_W-1:HALF] ^ vpn[HALF-1:0];

    // Fold the mixed half-word down to the bucket index width.
    always_comb begin
        idx = '0;
        for (int i = 0; i < HALF; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ mix[i];
        end
    end
endmodule

// File: rtl/hpt_rd_unit.sv
// Single-outstanding memory read sequencer.
// A start pulse launches one read; the request stays valid with a fixed
// address until ready, then the unit waits for one response beat and
// reports it through got/got_data. Assumes the response arrives at least
// one cycle after the request handshake and that start is only pulsed
// while no read is pending (or in the same cycle as got).
module hpt_rd_unit #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              got,
    output logic [DATA_W-1:0] got_data,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic waiting;

    assign got      = waiting && mem_rsp_valid;
    assign got_data = mem_rsp_data;

    // Request/response phase tracking for the single outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            mem_rd_addr  <= '0;
            waiting      <= 1'b0;
        end else begin
            if (got) begin
                waiting <= 1'b0;
            end
            if (mem_rd_valid && mem_rd_ready) begin
                mem_rd_valid <= 1'b0;
                waiting      <= 1'b1;
            end
            if (start) begin
                mem_rd_valid <= 1'b1;
                mem_rd_addr  <= start_addr;
            end
        end
    end

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R9
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!mem_rd_valid && (!waiting || got)));
endmodule

// File: rtl/hpt_hop_ctr.sv
// Chain element counter.
// Counts compared elements of the current lookup and flags when the
// configured maximum has been reached. Cleared at the start of each lookup.
module hpt_hop_ctr #(
    parameter int MAX_HOPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    logic [HOP_W-1:0] cnt;

    assign at_limit = (cnt == HOP_W'(MAX_HOPS));

    // Element count for the lookup in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + HOP_W'(1);
        end
    end

    // R6
    hop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= HOP_W'(MAX_HOPS));

    // R6
    hop_no_inc_at_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);
endmodule

// File: rtl/hpt_walker.sv
// Hashed page table chain walker (top).
// Hashes the request VPN to a bucket, reads the head pointer, then walks
// the chain of {vpn, frame, next} elements until a match, a zero pointer,
// or MAX_HOPS compared elements. Frame words are fetched only for the
// matching element. Assumes a memory returning one response per accepted
// read, no earlier than the cycle after the handshake.
module hpt_walker #(
    parameter int VPN_W     = 20,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int N_BUCKETS = 256,
    parameter int MAX_HOPS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ADDR_W-1:0] req_base,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              miss,
    output logic              err,
    output logic [DATA_W-1:0] frame,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    import hpt_pkg::*;

    localparam int IDX_W = $clog2(N_BUCKETS);
    localparam logic [ADDR_W-1:0] FRM_OFS  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] NEXT_OFS = ADDR_W'(8);

    walk_st_t          st;
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] cur_ptr;
    logic [IDX_W-1:0]  bkt_idx;
    logic              rd_start;
    logic [ADDR_W-1:0] rd_addr;
    logic              got;
    logic [DATA_W-1:0] got_data;
    logic              hop_clr;
    logic              hop_inc;
    logic              at_limit;
    logic              vpn_match;
    logic              ptr_null;

    hpt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
        .vpn (req_vpn),
        .idx (bkt_idx)
    );

    hpt_rd_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (rd_start),
        .start_addr    (rd_addr),
        .got           (got),
        .got_data      (got_data),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    hpt_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hop_clr),
        .inc      (hop_inc),
        .at_limit (at_limit)
    );

    assign busy      = (st != ST_IDLE);
    assign vpn_match = (got_data == DATA_W'(vpn_q));
    assign ptr_null  = (got_data == '0);

    // Pick the next read address and the hop counter controls for this cycle.
    always_comb begin
        rd_start = 1'b0;
        rd_addr  = '0;
        hop_clr  = 1'b0;
        hop_inc  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    rd_start = 1'b1;
                    rd_addr  = req_base + (ADDR_W'(bkt_idx) << 2);
                    hop_clr  = 1'b1;
                end
            end
            ST_HEAD: begin
                if (got && !ptr_null) begin
                    rd_start = 1'b1;
                    rd_addr  = ADDR_W'(got_data);
                end
            end
            ST_VPN: begin
                if (got) begin
                    rd_start = 1'b1;
                    if (vpn_match) begin
                        rd_addr = cur_ptr + FRM_OFS;
                    end else begin
                        rd_addr = cur_ptr + NEXT_OFS;
                        hop_inc = 1'b1;
                    end
                end
            end
            ST_NEXT: begin
                if (got && !ptr_null && !at_limit) begin
                    rd_start = 1'b1;
                    rd_addr  = ADDR_W'(got_data);
                end
            end
            default: ;
        endcase
    end

    // Walk state, current element pointer and the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            vpn_q   <= '0;
            cur_ptr <= '0;
            done    <= 1'b0;
            hit     <= 1'b0;
            miss    <= 1'b0;
            err     <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            hit  <= 1'b0;
            miss <= 1'b0;
            err  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q <= req_vpn;
                        st    <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (got) begin
                        if (ptr_null) begin
                            done <= 1'b1;
                            miss <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            cur_ptr <= ADDR_W'(got_data);
                            st      <= ST_VPN;
                        end
                    end
                end
                ST_VPN: begin
                    if (got) begin
                        st <= vpn_match ? ST_FRM : ST_NEXT;
                    end
                end
                ST_FRM: begin
                    if (got) begin
                        frame <= got_data;
                        done  <= 1'b1;
                        hit   <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_NEXT: begin
                    if (got) begin
                        if (ptr_null) begin
                            done <= 1'b1;
                            miss <= 1'b1;
                            st   <= ST_IDLE;
                        end else if (at_limit) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            cur_ptr <= ADDR_W'(got_data);
                            st      <= ST_VPN;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({hit, miss, err}));

    // R7
    flags_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(hit || miss || err));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(busy)));

    // R8
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(vpn_q));

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> $stable(frame));
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic [31:0] req_base = '0;
    logic        busy, done, hit, miss, err;
    logic [31:0] frame;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;

    logic [31:0] mem [0:4095];
    logic [31:0] rd_log [0:63];
    int          rd_n = 0;
    logic [7:0]  lfsr = 8'hA5;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;

    logic        r_hit, r_miss, r_err, r_busy_mid, r_busy_end, r_done_after;
    logic [31:0] r_frame;

    localparam logic [31:0] BASE = 32'h0000_0400;

    hpt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_base(req_base), .busy(busy), .done(done), .hit(hit), .miss(miss),
        .err(err), .frame(frame), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #5 clk = ~clk;

    // Memory model: random ready stalls, response 1-2 cycles after handshake.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[paddr[13:2]];
                pend = 1'b0;
            end else begin
                pcnt--;
            end
        end
        mem_rd_ready = lfsr[0] | lfsr[1];
        if (rst_n && mem_rd_valid && mem_rd_ready) begin
            pend  = 1'b1;
            pcnt  = int'(lfsr[2]);
            paddr = mem_rd_addr;
            if (rd_n < 64) rd_log[rd_n] = mem_rd_addr;
            rd_n++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nerr++;
                $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
                $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
                $finish;
            end
        end
    end

    function automatic logic [7:0] bidx(input logic [19:0] v);
        logic [9:0] h;
        h = v[19:10] ^ v[9:0];
        return h[7:0] ^ {6'b0, h[9:8]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
    endtask

    task automatic set_head(input logic [31:0] b, input logic [19:0] v, input logic [31:0] p);
        mem[(b + 32'(bidx(v)) * 4) >> 2] = p;
    endtask

    task automatic put_elem(input logic [31:0] p, input logic [31:0] v,
                            input logic [31:0] f, input logic [31:0] n);
        mem[p >> 2]       = v;
        mem[(p >> 2) + 1] = f;
        mem[(p >> 2) + 2] = n;
    endtask

    // One lookup; optionally pokes a second request while busy.
    task automatic lookup(input logic [19:0] v, input logic [31:0] b, input bit poke);
        int w;
        rd_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vpn = v; req_base = b;
        @(negedge clk);
        req_valid = 1'b0;
        r_busy_mid = busy;
        w = 0;
        while (!done && w < 3000) begin
            if (poke && w == 3) begin
                req_valid = 1'b1; req_vpn = v ^ 20'h00005; req_base = b + 32'h40;
            end
            @(negedge clk);
            req_valid = 1'b0;
            w++;
        end
        r_hit = hit; r_miss = miss; r_err = err; r_frame = frame; r_busy_end = busy;
        @(negedge clk);
        r_done_after = done;
    endtask

    task automatic t_reset();
        chk("R10", "busy", {31'b0, busy}, 32'd0);
        chk("R10", "done", {31'b0, done}, 32'd0);
        chk("R10", "flags", {29'b0, hit, miss, err}, 32'd0);
        chk("R10", "mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
    endtask

    task automatic t_empty_bucket();
        logic [19:0] v = 20'hABCDE;
        clear_mem();
        lookup(v, BASE, 1'b0);
        chk("R5", "empty bucket miss", {29'b0, r_hit, r_miss, r_err}, 32'b010);
        chk("R1", "read count", 32'(rd_n), 32'd1);
        chk("R1", "head addr", rd_log[0], BASE + 32'(bidx(v)) * 4);
        chk("R7", "busy during lookup", {31'b0, r_busy_mid}, 32'd1);
        chk("R7", "busy low at done", {31'b0, r_busy_end}, 32'd0);
        chk("R7", "done one cycle", {31'b0, r_done_after}, 32'd0);
    endtask

    task automatic t_hit_first();
        logic [19:0] v = 20'h12345;
        clear_mem();
        set_head(BASE, v, 32'h800);
        put_elem(32'h800, 32'(v), 32'hCAFE_0011, 32'h0);
        lookup(v, BASE, 1'b0);
        chk("R3", "hit flags", {29'b0, r_hit, r_miss, r_err}, 32'b100);
        chk("R3", "frame", r_frame, 32'hCAFE_0011);
        chk("R2", "read count", 32'(rd_n), 32'd3);
        chk("R2", "vpn addr", rd_log[1], 32'h800);
        chk("R2", "frame addr", rd_log[2], 32'h804);
    endtask

    task automatic t_hit_third();
        logic [19:0] v = 20'h0F0F3;
        bit touched = 1'b0;
        clear_mem();
        set_head(BASE, v, 32'h900);
        put_elem(32'h900, 32'(v ^ 20'h1), 32'h1111, 32'hA00);
        put_elem(32'hA00, 32'(v) | 32'h0010_0000, 32'h2222, 32'hB00);
        put_elem(32'hB00, 32'(v), 32'h3333_4444, 32'h0);
        lookup(v, BASE, 1'b0);
        chk("R3", "third hit flags", {29'b0, r_hit, r_miss, r_err}, 32'b100);
        chk("R3", "third frame", r_frame, 32'h3333_4444);
        chk("R4", "read count", 32'(rd_n), 32'd7);
        for (int i = 0; i < rd_n && i < 64; i++)
            if (rd_log[i] == 32'h904 || rd_log[i] == 32'hA04) touched = 1'b1;
        chk("R4", "mismatch frame untouched", {31'b0, touched}, 32'd0);
        chk("R4", "next ptr addr", rd_log[2], 32'h908);
        chk("R3", "last read frame", rd_log[6], 32'hB04);
    endtask

    task automatic t_miss_end();
        logic [19:0] v = 20'h55AA5;
        clear_mem();
        set_head(BASE, v, 32'hC00);
        put_elem(32'hC00, 32'h1, 32'h9, 32'hC40);
        put_elem(32'hC40, 32'h2, 32'h9, 32'h0);
        lookup(v, BASE, 1'b0);
        chk("R5", "chain end miss", {29'b0, r_hit, r_miss, r_err}, 32'b010);
        chk("R5", "read count", 32'(rd_n), 32'd5);
    endtask

    task automatic t_loop();
        logic [19:0] v = 20'h00777;
        clear_mem();
        set_head(BASE, v, 32'h800);
        put_elem(32'h800, 32'h3, 32'h9, 32'h800);
        lookup(v, BASE, 1'b0);
        chk("R6", "self loop err", {29'b0, r_hit, r_miss, r_err}, 32'b001);
        chk("R6", "loop read count", 32'(rd_n), 32'd33);
    endtask

    task automatic t_exact16(input bit match_last);
        logic [19:0] v = 20'h3C3C1;
        clear_mem();
        set_head(BASE, v, 32'h800);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] p = 32'h800 + 32'(k) * 16;
            logic [31:0] n = (k == 15) ? 32'h0 : p + 16;
            logic [31:0] sv = (match_last && k == 15) ? 32'(v) : 32'h7_0000 + 32'(k);
            put_elem(p, sv, 32'hF000 + 32'(k), n);
        end
        lookup(v, BASE, 1'b0);
        if (match_last) begin
            chk("R6", "16th element hit", {29'b0, r_hit, r_miss, r_err}, 32'b100);
            chk("R6", "16th frame", r_frame, 32'hF00F);
        end else begin
            chk("R6", "16 element chain miss", {29'b0, r_hit, r_miss, r_err}, 32'b010);
        end
        chk("R6", "16 element read count", 32'(rd_n), 32'd33);
    endtask

    task automatic t_busy_ignore();
        logic [19:0] v = 20'h2468A;
        int extra = 0;
        clear_mem();
        set_head(BASE, v, 32'h800);
        put_elem(32'h800, 32'h5, 32'h0, 32'h840);
        put_elem(32'h840, 32'(v), 32'hBEEF_0042, 32'h0);
        set_head(BASE + 32'h40, v ^ 20'h5, 32'h880);
        put_elem(32'h880, 32'(v ^ 20'h5), 32'hDEAD_0001, 32'h0);
        lookup(v, BASE, 1'b1);
        chk("R8", "result of first request", r_frame, 32'hBEEF_0042);
        chk("R8", "read count unchanged", 32'(rd_n), 32'd5);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk("R8", "no extra done or busy", 32'(extra), 32'd0);
        chk("R3", "frame held after idle", frame, 32'hBEEF_0042);
    endtask

    task automatic t_other_base();
        logic [19:0] v = 20'hFFFFF;
        logic [31:0] b = 32'h0000_1000;
        clear_mem();
        set_head(b, v, 32'h1800);
        put_elem(32'h1800, 32'(v), 32'h0BAD_F00D, 32'h0);
        lookup(v, b, 1'b0);
        chk("R1", "alt base head addr", rd_log[0], b + 32'(bidx(v)) * 4);
        chk("R3", "alt base frame", r_frame, 32'h0BAD_F00D);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_empty_bucket();
        t_hit_first();
        t_hit_third();
        t_miss_end();
        t_loop();
        t_exact16(1'b0);
        t_exact16(1'b1);
        t_busy_ignore();
        t_other_base();
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule